// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block collects five interrupt requests for a small processor core: one non-maskable source, three maskable restart sources (graded 7.5, 6.5 and 5.5) and one general-purpose request line. Every request passes through an input synchronizer. The block then applies the sensitivity rule that belongs to each source: edge, level, or edge qualified by level. It picks the highest-priority eligible source and, when the core marks an instruction boundary, issues a single-cycle accept pulse. The pulse carries the source's 16-bit vector address.

The block holds the global interrupt-enable flag, which software sets and clears, and a three-bit mask for the restart sources. It also holds the capture latches that the edge-sensitive sources need. When the general request wins, no fixed vector is given. The block drives an active-low acknowledge instead, so the core holds its program counter and fetches the instruction supplied by the device. Acceptance of any source clears the enable flag.

Top module: `irq_vec_ctrl`

## Requirements
- R1: While reset is held and directly after it, `take` is 0, `take_gen` is 0, `inta_n` is 1, `ie_flag` is 0, `r75_pend` is 0 and `mask_q` is 3'b111 (all restart sources masked).
- R2: When several sources are eligible, the winner is chosen in this fixed order, highest first: trap, restart 7.5, restart 6.5, restart 5.5, general request.
- R3: The vector on `take_vec` is 16'h0024 for trap, 16'h003C for 7.5, 16'h0034 for 6.5, 16'h002C for 5.5 and 16'h0000 for the general request.
- R4: Trap is recognized only after a rising edge and only while its level stays high. A pulse that falls before the boundary is dropped, and a level left high after acceptance is not accepted again.
- R5: A rising edge on restart 7.5 is latched and shown on `r75_pend`, even when it is masked. The latch stays set until 7.5 is accepted or `cfg_clr75` is pulsed.
- R6: Restart 6.5, restart 5.5 and the general request are level sensitive. A level that drops before the boundary causes no acceptance.
- R7: Restart and general requests are accepted only while `ie_flag` is 1. Each restart source also needs its own mask bit at 0: bit 2 for 7.5, bit 1 for 6.5 and bit 0 for 5.5, all written through `cfg_wr`/`cfg_mask`. Trap ignores both the flag and the mask.
- R8: When the general request is accepted, `take_gen` is 1 and `inta_n` is 0 for exactly the cycle in which `take` is 1. At all other times `inta_n` is 1.
- R9: Any acceptance leaves `ie_flag` at 0. `ie_set` sets the flag and `ie_clr` clears it; when both are given in one cycle, the flag clears.
- R10: Acceptance happens only on a clock edge where `insn_boundary` is 1, and `take` is then 1 for the cycle after that edge. Without a boundary, pending requests produce no pulse.
- R11: A request input is seen SYNC_STAGES+1 clock edges after it changes. A level raised just before edge 1, with the boundary held, yields `take` after edge SYNC_STAGES+1 and not earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| trap_in | input | 1 | Non-maskable request (edge and level) |
| r75_in | input | 1 | Restart 7.5 request (rising edge) |
| r65_in | input | 1 | Restart 6.5 request (level) |
| r55_in | input | 1 | Restart 5.5 request (level) |
| gen_req_in | input | 1 | General-purpose request (level) |
| insn_boundary | input | 1 | Core is at an instruction boundary |
| ie_set | input | 1 | Set the global enable flag |
| ie_clr | input | 1 | Clear the global enable flag |
| cfg_wr | input | 1 | Load the restart mask |
| cfg_mask | input | 3 | New mask; bit 2 = 7.5, bit 1 = 6.5, bit 0 = 5.5, 1 = masked |
| cfg_clr75 | input | 1 | Clear the 7.5 edge latch |
| take | output | 1 | Single-cycle accept pulse |
| take_vec | output | 16 | Vector of the accepted source, 0 when idle |
| take_gen | output | 1 | Accepted source is the general request |
| inta_n | output | 1 | Active-low acknowledge for the general request |
| ie_flag | output | 1 | Current global enable flag |
| mask_q | output | 3 | Current restart mask |
| r75_pend | output | 1 | 7.5 edge latch state |

## Verification
The bench builds the block with SYNC_STAGES = 2. This makes the input-to-accept latency of R11 short enough to probe cycle by cycle. It also lets each random step settle every synchronized edge within a few clocks before the boundary is pulsed. With that short latency, the random phase can cover mixed held levels, short 7.5 pulses, trap levels held across repeated boundaries, and mask and enable changes across hundreds of acceptances. Directed cases cover the same-cycle enable set and clear, a trap pulse that drops before the boundary, and the latency edge.

// File: rtl/irq_vec_pkg.sv
package irq_vec_pkg;

  localparam int VEC_W = 16;
  localparam int N_SRC = 5;

  // bit positions inside the synchronized request bundle
  localparam int B_TRAP = 4;
  localparam int B_R75  = 3;
  localparam int B_R65  = 2;
  localparam int B_R55  = 1;
  localparam int B_GEN  = 0;

  typedef enum logic [2:0] {
    SRC_NONE = 3'd0,
    SRC_TRAP = 3'd1,
    SRC_R75  = 3'd2,
    SRC_R65  = 3'd3,
    SRC_R55  = 3'd4,
    SRC_GEN  = 3'd5
  } src_e;

  localparam logic [VEC_W-1:0] VEC_TRAP = 16'h0024;
  localparam logic [VEC_W-1:0] VEC_R75  = 16'h003C;
  localparam logic [VEC_W-1:0] VEC_R65  = 16'h0034;
  localparam logic [VEC_W-1:0] VEC_R55  = 16'h002C;
  localparam logic [VEC_W-1:0] VEC_GEN  = 16'h0000;

  function automatic logic [VEC_W-1:0] vec_of(src_e s);
    case (s)
      SRC_TRAP: vec_of = VEC_TRAP;
      SRC_R75:  vec_of = VEC_R75;
      SRC_R65:  vec_of = VEC_R65;
      SRC_R55:  vec_of = VEC_R55;
      default:  vec_of = VEC_GEN;
    endcase
  endfunction

endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
  parameter int W      = 5,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  generate
    if (STAGES == 0) begin : g_bypass
      assign q = d;
    end else begin : g_chain
      logic [W-1:0] stage_q [STAGES];
      logic [W-1:0] stage_d [STAGES];

      for (genvar i = 0; i < STAGES; i++) begin : g_stage
        if (i == 0) begin : g_first
          assign stage_d[i] = d;
        end else begin : g_next
          assign stage_d[i] = stage_q[i-1];
        end

        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stage_q[i] <= '0;
          else        stage_q[i] <= stage_d[i];
        end
      end

      assign q = stage_q[STAGES-1];
    end
  endgenerate

endmodule

// File: rtl/irq_capture.sv
module irq_capture (
  input  logic clk,
  input  logic rst_n,
  input  logic trap_s,
  input  logic r75_s,
  input  logic trap_clr,
  input  logic r75_clr,
  output logic trap_live,
  output logic r75_pend
);

  logic trap_prev_q, r75_prev_q;
  logic trap_lat_q, trap_lat_d;
  logic r75_lat_q, r75_lat_d;
  logic trap_rise, r75_rise;

  assign trap_rise = trap_s & ~trap_prev_q;
  assign r75_rise  = r75_s & ~r75_prev_q;

  always_comb begin
    trap_lat_d = trap_lat_q;
    if (trap_rise)                trap_lat_d = 1'b1;
    else if (!trap_s || trap_clr) trap_lat_d = 1'b0;
  end

  // a fresh edge in the clearing cycle is kept
  always_comb begin
    r75_lat_d = r75_lat_q;
    if (r75_rise)     r75_lat_d = 1'b1;
    else if (r75_clr) r75_lat_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      trap_prev_q <= 1'b0;
      r75_prev_q  <= 1'b0;
      trap_lat_q  <= 1'b0;
      r75_lat_q   <= 1'b0;
    end else begin
      trap_prev_q <= trap_s;
      r75_prev_q  <= r75_s;
      trap_lat_q  <= trap_lat_d;
      r75_lat_q   <= r75_lat_d;
    end
  end

  assign trap_live = trap_lat_q & trap_s;
  assign r75_pend  = r75_lat_q;

endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
  import irq_vec_pkg::*;
(
  input  logic             trap_live,
  input  logic             r75_pend,
  input  logic             r65_lvl,
  input  logic             r55_lvl,
  input  logic             gen_lvl,
  input  logic             ie,
  input  logic [2:0]       mask,
  output src_e             win,
  output logic [VEC_W-1:0] win_vec
);

  logic ok75, ok65, ok55, okgen;

  assign ok75  = ie & r75_pend & ~mask[2];
  assign ok65  = ie & r65_lvl  & ~mask[1];
  assign ok55  = ie & r55_lvl  & ~mask[0];
  assign okgen = ie & gen_lvl;

  always_comb begin
    if (trap_live)  win = SRC_TRAP;
    else if (ok75)  win = SRC_R75;
    else if (ok65)  win = SRC_R65;
    else if (ok55)  win = SRC_R55;
    else if (okgen) win = SRC_GEN;
    else            win = SRC_NONE;
  end

  assign win_vec = vec_of(win);

endmodule

// File: rtl/irq_vec_ctrl.sv
module irq_vec_ctrl
  import irq_vec_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             trap_in,
  input  logic             r75_in,
  input  logic             r65_in,
  input  logic             r55_in,
  input  logic             gen_req_in,
  input  logic             insn_boundary,
  input  logic             ie_set,
  input  logic             ie_clr,
  input  logic             cfg_wr,
  input  logic [2:0]       cfg_mask,
  input  logic             cfg_clr75,
  output logic             take,
  output logic [VEC_W-1:0] take_vec,
  output logic             take_gen,
  output logic             inta_n,
  output logic             ie_flag,
  output logic [2:0]       mask_q,
  output logic             r75_pend
);

  // reset: asserted asynchronously, released on the clock
  logic rst_meta_q, rst_int_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_int_n  <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_int_n  <= rst_meta_q;
    end
  end

  logic [N_SRC-1:0] req_raw, req_s;
  assign req_raw[B_TRAP] = trap_in;
  assign req_raw[B_R75]  = r75_in;
  assign req_raw[B_R65]  = r65_in;
  assign req_raw[B_R55]  = r55_in;
  assign req_raw[B_GEN]  = gen_req_in;

  irq_sync #(.W(N_SRC), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_int_n),
    .d     (req_raw),
    .q     (req_s)
  );

  src_e             win;
  logic [VEC_W-1:0] win_vec;
  logic             accept;
  logic             trap_live, r75_lat;
  logic             ie_q, ie_d;
  logic [2:0]       mask_r, mask_d;
  logic             take_q, take_d, gen_q, gen_d;
  logic [VEC_W-1:0] vec_q, vec_d;

  assign accept = insn_boundary & (win != SRC_NONE);

  irq_capture u_cap (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .trap_s    (req_s[B_TRAP]),
    .r75_s     (req_s[B_R75]),
    .trap_clr  (accept & (win == SRC_TRAP)),
    .r75_clr   ((accept & (win == SRC_R75)) | cfg_clr75),
    .trap_live (trap_live),
    .r75_pend  (r75_lat)
  );

  irq_arbiter u_arb (
    .trap_live (trap_live),
    .r75_pend  (r75_lat),
    .r65_lvl   (req_s[B_R65]),
    .r55_lvl   (req_s[B_R55]),
    .gen_lvl   (req_s[B_GEN]),
    .ie        (ie_q),
    .mask      (mask_r),
    .win       (win),
    .win_vec   (win_vec)
  );

  always_comb begin
    ie_d = ie_q;
    if (ie_set)           ie_d = 1'b1;
    if (ie_clr || accept) ie_d = 1'b0;
    mask_d = cfg_wr ? cfg_mask : mask_r;
    take_d = accept;
    gen_d  = accept & (win == SRC_GEN);
    vec_d  = accept ? win_vec : '0;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      ie_q   <= 1'b0;
      mask_r <= 3'b111;
      take_q <= 1'b0;
      gen_q  <= 1'b0;
      vec_q  <= '0;
    end else begin
      ie_q   <= ie_d;
      mask_r <= mask_d;
      take_q <= take_d;
      gen_q  <= gen_d;
      vec_q  <= vec_d;
    end
  end

  assign take     = take_q;
  assign take_gen = gen_q;
  assign take_vec = vec_q;
  assign inta_n   = ~gen_q;
  assign ie_flag  = ie_q;
  assign mask_q   = mask_r;
  assign r75_pend = r75_lat;

endmodule

// File: rtl/irq_vec_ctrl_chk.sv
module irq_vec_ctrl_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        insn_boundary,
  input logic        take,
  input logic        take_gen,
  input logic [15:0] take_vec,
  input logic        inta_n,
  input logic        ie_flag
);

  // R10
  take_at_boundary_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> $past(insn_boundary));

  // R9
  ie_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> !ie_flag);

  // R8
  ack_only_gen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !inta_n |-> (take && take_gen));

  // R8
  gen_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (take && take_gen) |-> (!inta_n && take_vec == 16'h0000));

  // R3
  vec_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !take_gen) |-> (take_vec == 16'h0024 || take_vec == 16'h003C ||
                             take_vec == 16'h0034 || take_vec == 16'h002C));

  // R7
  maskable_needs_ie_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (take && take_vec != 16'h0024) |-> $past(ie_flag));

endmodule

bind irq_vec_ctrl irq_vec_ctrl_chk u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .insn_boundary (insn_boundary),
  .take          (take),
  .take_gen      (take_gen),
  .take_vec      (take_vec),
  .inta_n        (inta_n),
  .ie_flag       (ie_flag)
);

// File: tb/irq_vec_ctrl_tb.sv
`timescale 1ns/1ps
module irq_vec_ctrl_tb;

  localparam int S = 2;

  logic clk = 1'b0;
  logic rst_n;
  logic trap_in, r75_in, r65_in, r55_in, gen_req_in;
  logic insn_boundary, ie_set, ie_clr, cfg_wr, cfg_clr75;
  logic [2:0] cfg_mask;
  logic take, take_gen, inta_n, ie_flag, r75_pend;
  logic [15:0] take_vec;
  logic [2:0] mask_q;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  // bench model state
  bit m_ie, m_tl, m_75;
  bit [2:0] m_mask;
  bit p_trap, p_75;

  always #5 clk = ~clk;

  irq_vec_ctrl #(.SYNC_STAGES(S)) u_dut (
    .clk(clk), .rst_n(rst_n), .trap_in(trap_in), .r75_in(r75_in),
    .r65_in(r65_in), .r55_in(r55_in), .gen_req_in(gen_req_in),
    .insn_boundary(insn_boundary), .ie_set(ie_set), .ie_clr(ie_clr),
    .cfg_wr(cfg_wr), .cfg_mask(cfg_mask), .cfg_clr75(cfg_clr75),
    .take(take), .take_vec(take_vec), .take_gen(take_gen), .inta_n(inta_n),
    .ie_flag(ie_flag), .mask_q(mask_q), .r75_pend(r75_pend)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [17:0] predict(input bit tl, p75, l65, l55, lg, ie,
                                          input bit [2:0] m);
    if (tl)                return {2'b10, 16'h0024};
    if (ie && p75 && !m[2]) return {2'b10, 16'h003C};
    if (ie && l65 && !m[1]) return {2'b10, 16'h0034};
    if (ie && l55 && !m[0]) return {2'b10, 16'h002C};
    if (ie && lg)          return {2'b11, 16'h0000};
    return '0;
  endfunction

  task automatic do_ie(input bit s, input bit c);
    ie_set = s; ie_clr = c; cyc(1);
    ie_set = 0; ie_clr = 0;
    if (c) m_ie = 0; else if (s) m_ie = 1;
  endtask

  task automatic do_mask(input bit [2:0] m);
    cfg_wr = 1; cfg_mask = m; cyc(1);
    cfg_wr = 0; m_mask = m;
  endtask

  task automatic do_clr75();
    cfg_clr75 = 1; cyc(1); cfg_clr75 = 0; m_75 = 0;
  endtask

  // apply levels and keep model latches in step
  task automatic set_lv(input bit t, r75, r65, r55, g);
    trap_in = t; r75_in = r75; r65_in = r65; r55_in = r55; gen_req_in = g;
    if (t && !p_trap) m_tl = 1;
    if (!t) m_tl = 0;
    if (r75 && !p_75) m_75 = 1;
    p_trap = t; p_75 = r75;
  endtask

  // one boundary pulse, compare with the model, then check the pulse ends
  task automatic bnd(input string req);
    logic [17:0] e;
    e = predict(m_tl && p_trap, m_75, r65_in, r55_in, gen_req_in, m_ie, m_mask);
    insn_boundary = 1; cyc(1); insn_boundary = 0;
    chk(take == e[17], req, "take", take, e[17]);
    chk(take_gen == e[16], req, "take_gen", take_gen, e[16]);
    chk(take_vec == e[15:0], req, "take_vec", take_vec, e[15:0]);
    chk(inta_n == !(e[17] && e[16]), req, "inta_n", inta_n, !(e[17] && e[16]));
    if (e[17]) begin
      chk(ie_flag == 1'b0, "R9", "ie_flag after accept", ie_flag, 0);
      m_ie = 0;
      if (e[15:0] == 16'h0024) m_tl = 0;
      if (e[15:0] == 16'h003C) m_75 = 0;
    end
    cyc(1);
    chk(take == 1'b0, "R10", "pulse width", take, 0);
    chk(inta_n == 1'b1, "R8", "inta_n idle", inta_n, 1);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 0; insn_boundary = 0; ie_set = 0; ie_clr = 0; cfg_wr = 0;
    cfg_mask = 0; cfg_clr75 = 0;
    trap_in = 0; r75_in = 0; r65_in = 0; r55_in = 0; gen_req_in = 0;
    m_ie = 0; m_tl = 0; m_75 = 0; m_mask = 3'b111; p_trap = 0; p_75 = 0;
    cyc(3);
    chk(take == 0 && inta_n == 1 && take_gen == 0, "R1", "outputs in reset",
        {take, inta_n, take_gen}, 3'b010);
    rst_n = 1; cyc(3);
    chk(ie_flag == 0, "R1", "ie_flag", ie_flag, 0);
    chk(mask_q == 3'b111, "R1", "mask_q", mask_q, 3'b111);
    chk(r75_pend == 0, "R1", "r75_pend", r75_pend, 0);

    // R6 R3: a single level source
    do_mask(3'b000); do_ie(1, 0);
    set_lv(0, 0, 0, 1, 0); cyc(S + 2); bnd("R6");
    set_lv(0, 0, 0, 0, 0); cyc(S + 2);

    // R2: 6.5 over 5.5
    do_ie(1, 0); set_lv(0, 0, 1, 1, 0); cyc(S + 2); bnd("R2");
    set_lv(0, 0, 0, 0, 0); cyc(S + 2);

    // R5 R2: short 7.5 pulse beats held 6.5
    do_ie(1, 0); set_lv(0, 1, 1, 0, 0); cyc(1); set_lv(0, 0, 1, 0, 0);
    cyc(S + 2);
    chk(r75_pend == 1, "R5", "latch after pulse", r75_pend, 1);
    bnd("R5");
    chk(r75_pend == 0, "R5", "latch after accept", r75_pend, 0);

    // R10: pending 6.5 with no boundary gives no pulse
    do_ie(1, 0); cyc(S + 2);
    for (int i = 0; i < 6; i++) begin
      chk(take == 0, "R10", "no boundary", take, 0);
      cyc(1);
    end
    bnd("R10");
    set_lv(0, 0, 0, 0, 0); cyc(S + 2);

    // R7 R4: trap with enable off beats 6.5; held level is not re-taken
    do_ie(0, 1); set_lv(1, 0, 1, 0, 0); cyc(S + 2); bnd("R7");
    chk(take_vec == 16'h0000, "R3", "idle vector", take_vec, 0);
    bnd("R4");
    set_lv(0, 0, 0, 0, 0); cyc(S + 2);

    // R4: trap pulse gone before the boundary
    set_lv(1, 0, 0, 0, 0); cyc(1); set_lv(0, 0, 0, 0, 0); cyc(S + 2);
    bnd("R4");

    // R6: level dropped before the boundary
    do_ie(1, 0); set_lv(0, 0, 0, 1, 0); cyc(1); set_lv(0, 0, 0, 0, 0);
    cyc(S + 2); bnd("R6");

    // R7: mask on 6.5 lets 5.5 through; all masked gives nothing
    do_mask(3'b010); set_lv(0, 0, 1, 1, 0); cyc(S + 2); bnd("R7");
    do_mask(3'b111); do_ie(1, 0); bnd("R7");
    set_lv(0, 0, 0, 0, 0); cyc(S + 2);

    // R5: masked edge is latched, software clear drops it
    set_lv(0, 1, 0, 0, 0); cyc(1); set_lv(0, 0, 0, 0, 0); cyc(S + 2);
    chk(r75_pend == 1, "R5", "masked edge latched", r75_pend, 1);
    do_clr75(); cyc(1);
    chk(r75_pend == 0, "R5", "software clear", r75_pend, 0);
    do_mask(3'b000); bnd("R5");

    // R8: general request
    set_lv(0, 0, 0, 0, 1); cyc(S + 2); bnd("R8");
    do_ie(1, 0); do_ie(0, 1); bnd("R8");
    do_ie(1, 0); set_lv(0, 0, 0, 1, 1); cyc(S + 2); bnd("R2");
    set_lv(0, 0, 0, 0, 0); cyc(S + 2);

    // R9: set and clear in the same cycle
    do_ie(1, 1);
    chk(ie_flag == 0, "R9", "set with clear", ie_flag, 0);
    do_ie(1, 0);
    chk(ie_flag == 1, "R9", "set", ie_flag, 1);

    // R11: latency from input to accept
    set_lv(0, 0, 0, 1, 0); insn_boundary = 1;
    for (int k = 1; k <= S + 1; k++) begin
      cyc(1);
      chk(take == (k == S + 1), "R11", "latency", take, k == S + 1);
    end
    insn_boundary = 0; m_ie = 0;
    set_lv(0, 0, 0, 0, 0); cyc(S + 2);

    // random phase
    void'($urandom(32'h1234_5a5a));
    for (int it = 0; it < 400; it++) begin
      int r;
      bit t, a, b, c, g;
      r = $urandom_range(0, 99);
      if (r < 55) do_ie(1, 0); else if (r < 70) do_ie(0, 1);
      if ($urandom_range(0, 9) < 3) do_mask(3'($urandom_range(0, 7)));
      if ($urandom_range(0, 9) == 0) do_clr75();
      t = ($urandom_range(0, 9) < 2); a = $urandom_range(0, 1);
      b = $urandom_range(0, 1); c = $urandom_range(0, 1);
      g = $urandom_range(0, 1);
      if (!a && !p_75 && $urandom_range(0, 3) == 0) begin
        set_lv(p_trap, 1, r65_in, r55_in, gen_req_in); cyc(1);
      end
      set_lv(t, a, b, c, g);
      cyc(S + 2);
      bnd("R2");
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule